// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one 32-bit integer by another and returns a 32-bit quotient and a 32-bit remainder. It uses the restoring method. A double-width remainder register starts out holding the dividend. A double-width divisor register starts with the divisor in its upper half and shifts one place to the right on every step. On each step the divisor is trial-subtracted from the remainder. If the difference does not go below zero, it becomes the new remainder and a 1 enters the quotient. Otherwise the old remainder is kept, which is the restore, and a 0 enters the quotient. Thirty-three steps give the full result.

A `signed_mode` input chooses between unsigned and two's-complement operation. In signed mode the iteration runs on the magnitudes of the operands. One extra cycle then applies the signs: the quotient is negated when the operand signs differ, and a nonzero remainder takes the sign of the dividend. A zero divisor skips the iteration completely and raises a flag.

The caller waits for `ready`, presents the operands and pulses `start`. Results appear together with a one-cycle `done` pulse and stay on the outputs until the next operation finishes.

Top module: `div_restoring`

## Requirements
- R1: While reset is held and right after it, `ready` is 1 and `done`, `quotient`, `remainder` and `div_by_zero` are 0.
- R2: In unsigned mode (`signed_mode`=0) with a nonzero divisor, the results satisfy dividend = quotient*divisor + remainder, with remainder < divisor (for example 100/7 gives 14 r 2).
- R3: In signed mode (`signed_mode`=1) the quotient magnitude equals |dividend|/|divisor|. The quotient is negative exactly when the operand signs differ and it is nonzero. A nonzero remainder has the sign of the dividend. Examples: 7/2 gives 3 r 1, -7/2 gives -3 r -1, 7/-2 gives -3 r 1, -7/-2 gives 3 r -1.
- R4: In signed mode, the most negative value (0x80000000) divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: With a nonzero divisor, `done` rises on the 34th rising edge after the edge that accepts `start`. This is the 33 steps plus one sign-fix cycle.
- R6: A zero divisor sets `div_by_zero` to 1, returns quotient 0xFFFFFFFF and the dividend unchanged as the remainder, and raises `done` on the first edge after acceptance. The flag reads 0 after the next completion with a nonzero divisor.
- R7: `start` is accepted only while `ready` is 1. `ready` is 0 from the accepting edge until completion, and `start` during that time has no effect on the result.
- R8: `done` is a single-cycle pulse that rises together with `ready`. The outputs hold their values from one completion to the next.
- R9: A synchronous reset in the middle of an operation abandons it and returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a division; taken while ready is 1 |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse when new results are on the outputs |
| quotient | output | 32 | Quotient of the last completed operation |
| remainder | output | 32 | Remainder of the last completed operation |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
If the step counter is off by one, the latency changes and the quotient is shifted or loses its last bit, so any nonzero division already shows a wrong value on the same `done` pulse. An error in the trial subtraction, such as a borrow taken from the wrong bit, shows up only for particular operands. Large divisors and dividends with their top bit set make it visible within one operation. A wrong latched sign flag appears only in signed mode, and only for one combination of operand signs. For that reason the four sign combinations and the zero-remainder case are each driven once. A fault in the zero-divisor path shows as a wrong flag or as the wrong latency of one cycle.

// File: rtl/div_pkg.sv
// Shared definitions for the restoring divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package div_pkg;

    // Controller phases: waiting, iterating on magnitudes, applying signs.
    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_FIX  = 2'd2
    } div_state_e;

    // Conditional two's-complement negation for a 32-bit quantity.
    function automatic logic [31:0] neg_if32(input logic flip, input logic [31:0] val);
        return flip ? (32'd0 - val) : val;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
// Turns raw operands into the magnitudes the iteration works on, and
// produces the sign decisions for the final fix-up cycle.
// Assumes: combinational only; in unsigned mode the operands pass through.
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output logic         quo_neg,
    output logic         rem_neg,
    output logic         dvs_zero
);
    logic dvd_sign;
    logic dvs_sign;

    // Operand signs count only in signed mode.
    always_comb begin
        dvd_sign = signed_mode & dividend[W-1];
        dvs_sign = signed_mode & divisor[W-1];
    end

    // Magnitudes: negate negative operands (the most negative value maps to itself as unsigned).
    always_comb begin
        dvd_mag = dvd_sign ? (W'(0) - dividend) : dividend;
        dvs_mag = dvs_sign ? (W'(0) - divisor)  : divisor;
    end

    // Sign rules: quotient negative if the signs differ, remainder follows the dividend.
    always_comb begin
        quo_neg  = dvd_sign ^ dvs_sign;
        rem_neg  = dvd_sign;
        dvs_zero = (divisor == '0);
    end
endmodule

// File: rtl/div_step_unit.sv
// Restoring iteration datapath. It holds a double-width remainder, a
// double-width divisor that starts in the upper half and moves right one
// place per step, and the quotient shift register.
// Assumes: load and step are never asserted together; operands are magnitudes.
module div_step_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);
    localparam int RW = 2 * W;

    logic [RW-1:0] rem_q;
    logic [RW-1:0] dvr_q;
    logic [W-1:0]  quo_q;
    logic [RW:0]   trial;
    logic          fits;

    // Trial subtraction one bit wider than the registers, so a large divisor cannot fake a positive result.
    always_comb begin
        trial = {1'b0, rem_q} - {1'b0, dvr_q};
        fits  = ~trial[RW];
    end

    // Register update: load the operands, or take one restoring step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvr_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= {{W{1'b0}}, dvd_mag};
            dvr_q <= {dvs_mag, {W{1'b0}}};
            quo_q <= '0;
        end else if (step) begin
            if (fits) begin
                rem_q <= trial[RW-1:0];
            end
            dvr_q <= dvr_q >> 1;
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    // The remainder always fits in the low half once the steps are complete.
    always_comb begin
        quo_mag = quo_q;
        rem_mag = rem_q[W-1:0];
    end
endmodule

// File: rtl/div_sign_fix.sv
// Final correction: applies the latched signs to the magnitude results,
// or substitutes the fixed divide-by-zero response.
// Assumes: combinational; its inputs are stable during the fix-up cycle.
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         quo_neg,
    input  logic         rem_neg,
    input  logic         by_zero,
    input  logic [W-1:0] dvd_raw,
    output logic [W-1:0] quo_fix,
    output logic [W-1:0] rem_fix
);
    // Select the zero-divisor response or the sign-corrected magnitudes.
    always_comb begin
        if (by_zero) begin
            quo_fix = '1;
            rem_fix = dvd_raw;
        end else begin
            quo_fix = quo_neg ? (W'(0) - quo_mag) : quo_mag;
            rem_fix = rem_neg ? (W'(0) - rem_mag) : rem_mag;
        end
    end
endmodule

// File: rtl/div_restoring.sv
// Top of the restoring divider. A three-phase controller drives the step
// unit for W+1 steps, then registers the sign-corrected results and pulses
// done. A zero divisor goes straight to the fix-up phase.
// Assumes: operands are valid on the edge that accepts start.
module div_restoring #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         ready,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    import div_pkg::*;

    localparam int STEPS = W + 1;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    div_state_e      state_q;
    logic [CNT_W-1:0] step_cnt_q;
    logic            quo_neg_q;
    logic            rem_neg_q;
    logic            dz_q;
    logic [W-1:0]    dvd_raw_q;
    logic [W-1:0]    quo_out_q;
    logic [W-1:0]    rem_out_q;
    logic            dz_out_q;
    logic            done_q;

    logic [W-1:0]    dvd_mag;
    logic [W-1:0]    dvs_mag;
    logic            quo_neg;
    logic            rem_neg;
    logic            dvs_zero;
    logic [W-1:0]    quo_mag;
    logic [W-1:0]    rem_mag;
    logic [W-1:0]    quo_fix;
    logic [W-1:0]    rem_fix;
    logic            accept;
    logic            do_step;

    // Handshake decode: a request is taken only in the idle phase.
    always_comb begin
        accept  = (state_q == DIV_IDLE) && start;
        do_step = (state_q == DIV_RUN);
    end

    div_operand_prep #(.W(W)) prep_i (
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .quo_neg     (quo_neg),
        .rem_neg     (rem_neg),
        .dvs_zero    (dvs_zero)
    );

    div_step_unit #(.W(W)) step_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (do_step),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    div_sign_fix #(.W(W)) fix_i (
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .quo_neg (quo_neg_q),
        .rem_neg (rem_neg_q),
        .by_zero (dz_q),
        .dvd_raw (dvd_raw_q),
        .quo_fix (quo_fix),
        .rem_fix (rem_fix)
    );

    // Controller: phase sequencing, step counting and the operation context latched at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= DIV_IDLE;
            step_cnt_q <= '0;
            quo_neg_q  <= 1'b0;
            rem_neg_q  <= 1'b0;
            dz_q       <= 1'b0;
            dvd_raw_q  <= '0;
        end else begin
            case (state_q)
                DIV_IDLE: begin
                    if (start) begin
                        step_cnt_q <= '0;
                        quo_neg_q  <= quo_neg;
                        rem_neg_q  <= rem_neg;
                        dz_q       <= dvs_zero;
                        dvd_raw_q  <= dividend;
                        state_q    <= dvs_zero ? DIV_FIX : DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    step_cnt_q <= step_cnt_q + 1'b1;
                    if (step_cnt_q == LAST_STEP) begin
                        state_q <= DIV_FIX;
                    end
                end
                DIV_FIX: begin
                    state_q <= DIV_IDLE;
                end
                default: begin
                    state_q <= DIV_IDLE;
                end
            endcase
        end
    end

    // Result registers: written only in the fix-up phase, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_out_q <= '0;
            rem_out_q <= '0;
            dz_out_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state_q == DIV_FIX);
            if (state_q == DIV_FIX) begin
                quo_out_q <= quo_fix;
                rem_out_q <= rem_fix;
                dz_out_q  <= dz_q;
            end
        end
    end

    // Port drive.
    always_comb begin
        ready       = (state_q == DIV_IDLE);
        done        = done_q;
        quotient    = quo_out_q;
        remainder   = rem_out_q;
        div_by_zero = dz_out_q;
    end
endmodule

// File: rtl/div_restoring_chk.sv
// Port-level checker for the restoring divider, bound to every instance.
// Assumes: clocked on the design clock, synchronous active-low reset.
module div_restoring_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         signed_mode,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         ready,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero
);
    localparam int RW = 2 * W;

    logic [15:0]   busy_cnt;
    logic [W-1:0]  dvd_l;
    logic [W-1:0]  dvs_l;
    logic          mode_l;
    logic [RW-1:0] rebuilt;

    // Track the cycles since acceptance and the operands of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            dvd_l    <= '0;
            dvs_l    <= '0;
            mode_l   <= 1'b0;
        end else if (ready && start) begin
            busy_cnt <= '0;
            dvd_l    <= dividend;
            dvs_l    <= divisor;
            mode_l   <= signed_mode;
        end else if (!ready) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // Reconstruct the dividend from the reported results.
    always_comb begin
        rebuilt = RW'(quotient) * RW'(dvs_l) + RW'(remainder);
    end

    // R7: an accepted request makes the block busy.
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    // R6: a zero divisor completes one cycle after the busy cycle, with the flag set.
    a_r6_dz_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && divisor == '0) |=> ##1 (done && div_by_zero));

    // R8: done is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done coincides with the return of ready.
    a_r8_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R8: outputs do not move while an operation is in flight.
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

    // R5: a nonzero divisor completes exactly W+2 edges after acceptance.
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (busy_cnt == 16'(W + 2)));

    // R2: unsigned results rebuild the dividend, and the remainder is below the divisor.
    a_r2_unsigned_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero && !mode_l) |-> (rebuilt == RW'(dvd_l) && remainder < dvs_l));

    // R3: in signed mode a nonzero remainder carries the dividend's sign.
    a_r3_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero && mode_l && remainder != '0) |-> (remainder[W-1] == dvd_l[W-1]));
endmodule

bind div_restoring div_restoring_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .ready       (ready),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
);

// File: tb/div_restoring_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, busy-time start, result holding and mid-run reset.
module div_restoring_tb_top;
    localparam int W = 32;
    localparam int NVEC = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         ready;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Entry layout: {signed, dividend, divisor, quotient, remainder, dz}.
    localparam logic [129:0] VEC [NVEC] = '{
        {1'b0, 32'd100,        32'd7,          32'd14,         32'd2,          1'b0},
        {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0,          1'b0},
        {1'b0, 32'd5,          32'd9,          32'd0,          32'd5,          1'b0},
        {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0,          1'b0},
        {1'b0, 32'h80000000,   32'd3,          32'h2AAAAAAA,   32'd2,          1'b0},
        {1'b1, 32'd7,          32'd2,          32'd3,          32'd1,          1'b0},
        {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF,   1'b0},
        {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1,          1'b0},
        {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF,   1'b0},
        // R4: most negative value over -1
        {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0,          1'b0},
        {1'b1, 32'hFFFFFFFA,   32'd3,          32'hFFFFFFFE,   32'd0,          1'b0},
        {1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC,   32'd1,          1'b0},
        {1'b0, 32'd12345,      32'd0,          32'hFFFFFFFF,   32'd12345,      1'b1},
        {1'b1, 32'hFFFFFFF9,   32'd0,          32'hFFFFFFFF,   32'hFFFFFFF9,   1'b1}
    };

    div_restoring #(.W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .ready       (ready),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Issue one request at a falling edge; it is taken on the next rising edge.
    task automatic issue(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b);
        signed_mode = sm;
        dividend    = a;
        divisor     = b;
        start       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Count rising edges after acceptance until done is seen.
    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 1000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1", "ready in reset", W'(ready), W'(1));
        check("R1", "done in reset", W'(done), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", W'(ready), W'(1));
        check("R1", "quotient after reset", quotient, '0);
        check("R1", "remainder after reset", remainder, '0);
        check("R1", "flag after reset", W'(div_by_zero), W'(0));

        // R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [129:0] v;
            string tag;
            v = VEC[i];
            tag = v[0] ? "R6" : (v[129] ? "R3" : "R2");
            issue(v[129], v[128:97], v[96:65]);
            wait_done(n);
            check(tag, $sformatf("quotient vec%0d", i), quotient, v[64:33]);
            check(tag, $sformatf("remainder vec%0d", i), remainder, v[32:1]);
            check(tag, $sformatf("flag vec%0d", i), W'(div_by_zero), W'(v[0]));
            check("R5", $sformatf("latency vec%0d", i), W'(n), v[0] ? W'(1) : W'(W + 2));
            @(negedge clk);
        end

        // R7: start while busy is ignored
        issue(1'b0, 32'd100, 32'd7);
        check("R7", "ready while busy", W'(ready), W'(0));
        signed_mode = 1'b1;
        dividend = 32'd50;
        divisor = 32'd0;
        start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        wait_done(n);
        check("R7", "quotient after busy start", quotient, 32'd14);
        check("R7", "flag after busy start", W'(div_by_zero), W'(0));
        check("R8", "ready with done", W'(ready), W'(1));

        // R8: done is a pulse and the results are held
        repeat (3) @(negedge clk);
        check("R8", "done low after pulse", W'(done), W'(0));
        check("R8", "quotient held", quotient, 32'd14);
        check("R8", "remainder held", remainder, 32'd2);

        // R9: reset in mid-operation
        issue(1'b0, 32'd1000, 32'd3);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ready after abort", W'(ready), W'(1));
        check("R9", "quotient after abort", quotient, '0);
        check("R9", "done after abort", W'(done), W'(0));
        repeat (40) @(negedge clk);
        check("R9", "no late done", W'(done), W'(0));
        check("R9", "remainder stays clear", remainder, '0);

        report();
    end
endmodule